// File: doc/BRIEF.md
# SPI Serial Clock Divider with Mode Control

This block derives the serial clock of an SPI master from the system clock, along with one-cycle strobes that tell a shift register when to drive the next bit and when to capture the incoming one. A 5-bit prescale field sets the divide ratio. It uses a split encoding. With the top bit clear, the low four bits are the ratio itself, from 1 to 15. With the top bit set, the ratio is twice the low four bits, which covers even ratios up to 30. Clock polarity chooses the resting level of the serial clock. Clock phase chooses which edge launches data and which edge captures it. A capture-edge control moves the capture strobe to the other edge, which is needed at ratios of 2 or less.

The prescale, polarity, phase and capture-edge inputs are taken in only while `run` is low. Raising `run` starts the clock at the resting level. Lowering it returns the clock to rest on the next cycle. When the ratio is 1, the system clock is passed through as the serial clock, and every cycle carries both a launch and a capture. The first bit of a phase-0 transfer is expected to be on the data line before `run` rises, because that mode has no launch edge ahead of the first capture.

Top module: `spiclk_gen`

## Requirements
- R1: With prescale bit 4 at 0, the serial clock period is N system cycles, where N is bits 3:0. A value of 0 is treated as N = 1.
- R2: With prescale bit 4 at 1, the period is twice bits 3:0, giving 2 to 30 cycles. A lower field of 0 is treated as a ratio of 1.
- R3: For ratios of 2 or more, each period starts with ceil(N/2) cycles at the resting level, followed by floor(N/2) cycles at the opposite level. The first period begins in the first cycle after `run` is sampled high.
- R4: From the cycle after `run` is sampled low, `sclk` equals `cpol`, and `launch` and `sample` are both 0.
- R5: With `cpha` = 0 and `capt_edge` = 0, `sample` pulses on each leading edge (rest to active) and `launch` pulses on each trailing edge (active to rest). Each pulse is high for the one cycle in which `sclk` first shows the new level.
- R6: With `cpha` = 1 and `capt_edge` = 0, `launch` pulses on each leading edge and `sample` pulses on each trailing edge.
- R7: With `capt_edge` = 1, `sample` moves to the edge opposite the one its phase selects. `launch` does not change.
- R8: At a ratio of 1 while running, `sclk` equals `cpol` while `clk` is high and the inverse of `cpol` while `clk` is low. `launch` and `sample` are both high in every cycle.
- R9: Changes to prescale, `cpol`, `cpha` or `capt_edge` while `run` is high have no effect on `sclk`, `launch` or `sample` until `run` is lowered.
- R10: While `rst_n` is low, `sclk`, `launch` and `sample` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to generate the serial clock; low holds it at rest |
| prescale | input | 5 | Split-encoded divide ratio |
| cpol | input | 1 | Resting level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: launch on leading edge |
| capt_edge | input | 1 | Moves the capture strobe to the opposite edge |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe to drive the next bit |
| sample | output | 1 | One-cycle strobe to capture the incoming bit |

## Verification
The bench runs the clock at the smallest and largest ratios, at odd ratios and at even-step ratios, and checks every cycle against a model of the period. These runs would expose a decoder that treats bit 4 as a plain binary digit, or that produces a ratio of 0. Odd ratios show whether the shorter half falls on the active level. A design that gets this wrong puts the leading edge one cycle early or late. Every combination of phase and capture-edge setting is checked strobe by strobe, so a swapped edge or a duplicated pulse is reported. At ratio 1, the clock level is checked in both halves of the system clock. The bench also changes the configuration in the middle of a run, which would expose a design that picks up the new values before `run` is lowered.

// File: rtl/spiclk_pkg.sv
`timescale 1ns/1ps
package spiclk_pkg;
    // Width of the split-encoded prescale field.
    localparam int unsigned PRE_W = 5;
    // A ratio of twice the largest low field fits in PRE_W bits.
    localparam int unsigned RAT_W = PRE_W;

    typedef struct packed {
        logic [RAT_W-1:0] ratio;     // system cycles per serial period
        logic [RAT_W-1:0] idle_len;  // cycles at the resting level, ceil(ratio/2)
        logic             div1;      // ratio of one: clock pass-through
        logic             cpol;
        logic             cpha;
        logic             capt;
    } clk_cfg_t;
endpackage

// File: rtl/spiclk_ratio_dec.sv
`timescale 1ns/1ps
module spiclk_ratio_dec
    import spiclk_pkg::*;
#(
    parameter int unsigned PW = PRE_W,
    localparam int unsigned RW = PW
) (
    input  logic [PW-1:0] prescale,
    output logic [RW-1:0] ratio,
    output logic [RW-1:0] idle_len,
    output logic          div1
);
    logic [PW-2:0] low_bits;
    logic [RW-1:0] raw;

    always_comb begin
        low_bits = prescale[PW-2:0];
        // Top bit selects even steps, otherwise direct divide.
        if (prescale[PW-1]) begin
            raw = {low_bits, 1'b0};
        end else begin
            raw = {1'b0, low_bits};
        end
        // A zero ratio cannot be generated; fold it onto one.
        if (raw == '0) begin
            raw = RW'(1);
        end
        ratio    = raw;
        idle_len = (raw >> 1) + RW'(raw[0]);
        div1     = (raw == RW'(1));
    end
endmodule

// File: rtl/spiclk_cfg_hold.sv
`timescale 1ns/1ps
module spiclk_cfg_hold
    import spiclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  clk_cfg_t cfg_in,
    output clk_cfg_t cfg_q
);
    clk_cfg_t cfg_d;

    always_comb begin
        // Settings are taken in only while the clock is at rest.
        cfg_d = run ? cfg_q : cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{ratio: RAT_W'(1), idle_len: RAT_W'(1), div1: 1'b1,
                       cpol: 1'b0, cpha: 1'b0, capt: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(cfg_q)); // R9
endmodule

// File: rtl/spiclk_phase_cnt.sv
`timescale 1ns/1ps
module spiclk_phase_cnt
    import spiclk_pkg::*;
#(
    parameter int unsigned RW = RAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] ratio,
    input  logic [RW-1:0] idle_len,
    output logic          active_q,
    output logic          lead_nx,
    output logic          trail_nx,
    output logic          act_lvl_nx
);
    typedef struct packed {
        logic          active;
        logic [RW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d.active = run;
        if (!run || !st_q.active) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == ratio - RW'(1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + RW'(1);
        end
        // Position in the period that the next cycle will show.
        act_lvl_nx = run && (st_d.cnt >= idle_len);
        lead_nx    = run && (st_d.cnt == idle_len);
        trail_nx   = run && st_q.active && (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_q = st_q.active;

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt < ratio)); // R3
endmodule

// File: rtl/spiclk_gen.sv
`timescale 1ns/1ps
module spiclk_gen
    import spiclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             capt_edge,
    output logic             sclk,
    output logic             launch,
    output logic             sample
);
    typedef struct packed {
        logic sclk;
        logic launch;
        logic sample;
    } out_st_t;

    clk_cfg_t cfg_in, cfg_q;
    logic     act_q, lead_nx, trail_nx, act_lvl_nx;
    logic     samp_on_lead;
    out_st_t  out_d, out_q;

    spiclk_ratio_dec #(.PW(PRE_W)) dec_i (
        .prescale (prescale),
        .ratio    (cfg_in.ratio),
        .idle_len (cfg_in.idle_len),
        .div1     (cfg_in.div1)
    );

    assign cfg_in.cpol = cpol;
    assign cfg_in.cpha = cpha;
    assign cfg_in.capt = capt_edge;

    spiclk_cfg_hold hold_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    spiclk_phase_cnt #(.RW(RAT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .ratio      (cfg_q.ratio),
        .idle_len   (cfg_q.idle_len),
        .active_q   (act_q),
        .lead_nx    (lead_nx),
        .trail_nx   (trail_nx),
        .act_lvl_nx (act_lvl_nx)
    );

    always_comb begin
        // Phase 0 captures on the leading edge; the capture-edge bit flips it.
        samp_on_lead = (!cfg_q.cpha) ^ cfg_q.capt;
        if (!run) begin
            out_d = '{sclk: cpol, launch: 1'b0, sample: 1'b0};
        end else if (cfg_q.div1) begin
            out_d = '{sclk: cfg_q.cpol, launch: 1'b1, sample: 1'b1};
        end else begin
            out_d.sclk   = cfg_q.cpol ^ act_lvl_nx;
            out_d.launch = cfg_q.cpha ? lead_nx : trail_nx;
            out_d.sample = samp_on_lead ? lead_nx : trail_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // Ratio of one: rest level in the high half of clk, active in the low half.
    assign sclk   = (act_q && cfg_q.div1) ? (cfg_q.cpol ^ ~clk) : out_q.sclk;
    assign launch = out_q.launch;
    assign sample = out_q.sample;

    AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> (out_q.sclk == cfg_q.cpol) && !out_q.launch && !out_q.sample); // R4
    AST_PULSE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !cfg_q.div1 && (out_q.launch || out_q.sample))
        |-> (out_q.sclk != $past(out_q.sclk))); // R5
    AST_SPLIT_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !cfg_q.div1 && !cfg_q.capt) |-> !(out_q.launch && out_q.sample)); // R6
    AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && cfg_q.div1) |-> (out_q.launch && out_q.sample)); // R8
endmodule

// File: tb/spiclk_gen_tb_top.sv
`timescale 1ns/1ps
module spiclk_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run;
    logic [4:0] prescale;
    logic       cpol, cpha, capt_edge;
    logic       sclk, launch, sample;
    int         n_chk = 0;
    int         n_err = 0;

    always #2.5 clk = ~clk;

    spiclk_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .prescale  (prescale),
        .cpol      (cpol),
        .cpha      (cpha),
        .capt_edge (capt_edge),
        .sclk      (sclk),
        .launch    (launch),
        .sample    (sample)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int ratio_of(input logic [4:0] p);
        int r;
        r = p[4] ? 2 * int'(p[3:0]) : int'(p[3:0]);
        return (r == 0) ? 1 : r;
    endfunction

    // One scenario: configure, check rest, run for whole periods, stop, check rest.
    task automatic run_case(input string tag, input logic [4:0] pre, input logic pol,
                            input logic pha, input logic cap, input int periods,
                            input bit scramble);
        int    n, l, c, total;
        logic  lvl, lead, trail, sol;
        string ptag;
        @(negedge clk);
        prescale = pre; cpol = pol; cpha = pha; capt_edge = cap; run = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R4", "rest sclk", sclk, pol);
        chk("R4", "rest launch", launch, 1'b0);
        chk("R4", "rest sample", sample, 1'b0);
        n = ratio_of(pre);
        l = (n + 1) / 2;
        total = n * periods;
        ptag = cap ? "R7" : (pha ? "R6" : "R5");
        @(negedge clk);
        run = 1'b1;
        for (int j = 0; j < total; j++) begin
            @(posedge clk); #1;
            if (scramble && j == 1) begin
                prescale = ~pre; cpol = ~pol; cpha = ~pha; capt_edge = ~cap;
            end
            c = j % n;
            if (n == 1) begin
                chk(tag, "sclk high half", sclk, pol);
                chk("R8", "launch every cycle", launch, 1'b1);
                chk("R8", "sample every cycle", sample, 1'b1);
                @(negedge clk); #1;
                chk("R8", "sclk low half", sclk, ~pol);
            end else begin
                lvl   = pol ^ (c >= l);
                lead  = (c == l);
                trail = (c == 0) && (j > 0);
                sol   = (!pha) ^ cap;
                chk(tag, "sclk level", sclk, lvl);
                chk(ptag, "launch", launch, pha ? lead : trail);
                chk(ptag, "sample", sample, sol ? lead : trail);
            end
        end
        @(negedge clk);
        prescale = pre; cpol = pol; cpha = pha; capt_edge = cap; run = 1'b0;
        @(posedge clk); #1;
        chk("R4", "stop sclk", sclk, pol);
        chk("R4", "stop launch", launch, 1'b0);
        chk("R4", "stop sample", sample, 1'b0);
    endtask

    task automatic reset_case();
        rst_n = 1'b0; run = 1'b0; prescale = 5'd4; cpol = 1'b1; cpha = 1'b0; capt_edge = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "reset sclk", sclk, 1'b0);
        chk("R10", "reset launch", launch, 1'b0);
        chk("R10", "reset sample", sample, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        reset_case();
        run_case("R1", 5'd4,       1'b0, 1'b0, 1'b0, 3, 1'b0);
        run_case("R3", 5'd3,       1'b1, 1'b1, 1'b0, 3, 1'b0);
        run_case("R3", 5'd5,       1'b0, 1'b0, 1'b1, 3, 1'b0);
        run_case("R1", 5'd15,      1'b1, 1'b0, 1'b0, 2, 1'b0);
        run_case("R1", 5'd0,       1'b0, 1'b0, 1'b0, 4, 1'b0);
        run_case("R1", 5'd1,       1'b1, 1'b1, 1'b1, 4, 1'b0);
        run_case("R2", 5'b1_1000,  1'b0, 1'b1, 1'b0, 2, 1'b0);
        run_case("R2", 5'b1_1111,  1'b1, 1'b0, 1'b0, 2, 1'b0);
        run_case("R2", 5'b1_0000,  1'b0, 1'b0, 1'b0, 3, 1'b0);
        run_case("R2", 5'b1_0011,  1'b0, 1'b1, 1'b1, 2, 1'b0);
        run_case("R7", 5'd2,       1'b0, 1'b1, 1'b1, 4, 1'b0);
        run_case("R7", 5'd2,       1'b1, 1'b0, 1'b1, 4, 1'b0);
        run_case("R9", 5'd6,       1'b0, 1'b0, 1'b0, 3, 1'b1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired before the scenarios finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule